// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO with Rewind

This block is a first-in first-out buffer for 18-bit words with a write port and a read port that run on unrelated clocks. The depth is a power of two set by a parameter. A master reset clears the buffer and latches one of two read protocols. In standard mode a word reaches the data output only after a read request, and the two flags report full and empty. In fall-through mode the oldest word is presented on the output without any request. In that mode the same two flags report space available and word present.

A partial reset empties the buffer and keeps the protocol chosen at the last master reset. A rewind request on the read clock moves only the read position back to memory location zero, so words already consumed can be read again. A separate output goes high while more than half of the memory locations hold unread words. Pointers cross between the clock domains as Gray code through two-flop synchronisers. Each flag therefore lags a change made by the opposite port by a few cycles. During that lag it errs on the safe side.

Top module: `dmfifo`

## Requirements
- R1: After either reset, dout is all zeroes and over_half is 0. In standard mode wflag is 0 and rflag is 1. In fall-through mode wflag is 1 and rflag is 0.
- R2: The protocol is taken from fwft_sel (1 = fall-through, 0 = standard) while mrst is high. A partial reset (prst) leaves the protocol unchanged.
- R3: In standard mode dout changes only on a rising rclk with ren high and the buffer not empty. Successive reads return the words in the order they were written.
- R4: In standard mode wflag is 1 exactly when DEPTH words are stored, and rflag is 1 exactly when no unread word is stored (flags after the pointers have settled).
- R5: In fall-through mode the oldest word appears on dout without ren, and rflag is 1 while it is valid. A rising rclk with ren high consumes that word. The next word, if any, then replaces it.
- R6: In fall-through mode the output register holds one word beyond the DEPTH memory locations. wflag is 1 while the memory can accept a word and 0 once DEPTH+1 words are buffered.
- R7: A write attempted while the buffer is full is dropped and does not disturb the stored words or their order.
- R8: A read attempted while the buffer is empty leaves dout and the read position unchanged.
- R9: over_half is 1 exactly when more than DEPTH/2 words sit in the memory locations. In fall-through mode the word held in the output register is not counted.
- R10: A rising rclk with rt high sets the read position to location zero and leaves the write position unchanged. Later reads return the words from location zero onward.
- R11: On the rclk edge that takes rt, rflag goes to 1 in standard mode (empty) or to 0 in fall-through mode (no word present).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, synchronous, active high, held for several edges of both clocks |
| prst | input | 1 | Partial reset, keeps the protocol, same timing as mrst |
| fwft_sel | input | 1 | Protocol select sampled during mrst |
| wen | input | 1 | Write enable (wclk domain) |
| din | input | DATA_W | Write data |
| ren | input | 1 | Read enable (rclk domain) |
| rt | input | 1 | Rewind read position to location zero (rclk domain) |
| dout | output | DATA_W | Read data register |
| wflag | output | 1 | Full (standard) or space available (fall-through) |
| rflag | output | 1 | Empty (standard) or word present (fall-through) |
| over_half | output | 1 | More than DEPTH/2 words in memory (wclk domain) |

## Verification
A written word shows up on the read side two rclk edges after the wclk edge that stores it. A standard read can take it on the following edge, and a fall-through fetch loads it on that same edge. A read or fetch takes two wclk edges to reach wflag and over_half. A standard read updates dout on the rclk edge that samples ren, and the rewind flag change appears on the edge that samples rt. Inputs change on the falling edge of their own clock. After every burst the bench waits six edges of each clock before it samples flags, so all crossing delays have passed. Data and rewind-flag results are read at the falling edge right after the rising edge that produced them.

// File: rtl/dmfifo_pkg.sv
package dmfifo_pkg;

    localparam int WORD_W = 18;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;

    typedef struct packed {
        logic valid;    // fall-through output register holds a word
        logic rt_hold;  // one-cycle fetch block after a rewind
    } rd_state_t;

    // pick the flag meaning for the active protocol
    function automatic logic mode_flag(input fifo_mode_e m, input logic std_v, input logic fwft_v);
        return (m == MODE_FWFT) ? fwft_v : std_v;
    endfunction

endpackage

// File: rtl/dmfifo_ptr_cdc.sv
module dmfifo_ptr_cdc #(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          clr,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    logic [PW-1:0] meta_q;
    logic [PW-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_in;
            sync_q <= meta_q;
        end
    end

    // Gray to binary: each bit is the parity of itself and all higher bits
    always_comb begin
        for (int i = 0; i < PW; i++) begin
            bin_out[i] = ^(sync_q >> i);
        end
    end

endmodule

// File: rtl/dmfifo_mem.sv
module dmfifo_mem #(
    parameter int W  = 18,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int CELLS = 1 << AW;

    logic [W-1:0] cells [CELLS];

    always_ff @(posedge wclk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/dmfifo_wside.sv
module dmfifo_wside
    import dmfifo_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic        clk,
    input  logic        mrst,
    input  logic        prst,
    input  logic        fwft_sel,
    input  logic        wen,
    input  logic [AW:0] rbin_sync,
    output logic [AW:0] wgray,
    output logic [AW-1:0] waddr,
    output logic        we,
    output logic        wflag,
    output logic        over_half
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam int HALF  = DEPTH / 2;

    fifo_mode_e    mode;
    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_nx;
    logic [PW-1:0] used;
    logic          full;

    assign used    = wbin - rbin_sync;
    assign full    = (used == PW'(DEPTH));
    assign we      = wen && !full;
    assign waddr   = wbin[AW-1:0];
    assign wbin_nx = wbin + PW'(1);

    always_ff @(posedge clk) begin
        if (mrst) begin
            mode <= fwft_sel ? MODE_FWFT : MODE_STD;
        end
    end

    always_ff @(posedge clk) begin
        if (mrst || prst) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (we) begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    assign wflag     = mode_flag(mode, full, !full);
    assign over_half = (used > PW'(HALF));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (mrst || prst)
        (wen && full) |=> $stable(wbin));

    // R6
    fill_bound_chk: assert property (@(posedge clk) disable iff (mrst || prst)
        used <= PW'(DEPTH));

    // R2
    wmode_hold_chk: assert property (@(posedge clk) disable iff (mrst)
        1'b1 |=> $stable(mode));

endmodule

// File: rtl/dmfifo_rside.sv
module dmfifo_rside
    import dmfifo_pkg::*;
#(
    parameter int AW = 4,
    parameter int W  = 18
) (
    input  logic          clk,
    input  logic          mrst,
    input  logic          prst,
    input  logic          fwft_sel,
    input  logic          ren,
    input  logic          rt,
    input  logic [AW:0]   wbin_sync,
    input  logic [W-1:0]  mem_q,
    output logic [AW:0]   rgray,
    output logic [AW-1:0] raddr,
    output logic [W-1:0]  dout,
    output logic          rflag
);
    localparam int PW = AW + 1;

    fifo_mode_e    mode;
    rd_state_t     st;
    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_nx;
    logic          empty;
    logic          fetch;
    logic          drop;

    assign empty   = (rbin == wbin_sync);
    assign raddr   = rbin[AW-1:0];
    assign rbin_nx = rbin + PW'(1);

    always_comb begin
        if (mode == MODE_FWFT) begin
            fetch = (!st.valid || ren) && !empty && !st.rt_hold && !rt;
            drop  = ren && st.valid && !fetch && !rt;
        end else begin
            fetch = ren && !empty && !st.rt_hold && !rt;
            drop  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (mrst) begin
            mode <= fwft_sel ? MODE_FWFT : MODE_STD;
        end
    end

    always_ff @(posedge clk) begin
        if (mrst || prst) begin
            rbin  <= '0;
            rgray <= '0;
            dout  <= '0;
            st    <= '0;
        end else if (rt) begin
            rbin       <= '0;
            rgray      <= '0;
            st.valid   <= 1'b0;
            st.rt_hold <= 1'b1;
        end else begin
            st.rt_hold <= 1'b0;
            if (fetch) begin
                dout     <= mem_q;
                rbin     <= rbin_nx;
                rgray    <= rbin_nx ^ (rbin_nx >> 1);
                st.valid <= 1'b1;
            end else if (drop) begin
                st.valid <= 1'b0;
            end
        end
    end

    assign rflag = mode_flag(mode, empty || st.rt_hold, st.valid);

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (mrst || prst)
        (ren && empty && !rt) |=> $stable(rbin));

    // R10
    rewind_ptr_chk: assert property (@(posedge clk) disable iff (mrst || prst)
        rt |=> (rgray == '0));

    // R11
    rewind_flag_chk: assert property (@(posedge clk) disable iff (mrst || prst)
        rt |=> (rflag == (mode == MODE_STD)));

    // R3
    std_hold_chk: assert property (@(posedge clk) disable iff (mrst || prst)
        (mode == MODE_STD && !ren) |=> $stable(dout));

    // R5
    fwft_hold_chk: assert property (@(posedge clk) disable iff (mrst || prst)
        (mode == MODE_FWFT && st.valid && !ren && !rt) |=> (st.valid && $stable(dout)));

endmodule

// File: rtl/dmfifo.sv
module dmfifo
    import dmfifo_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              mrst,
    input  logic              prst,
    input  logic              fwft_sel,
    input  logic              wen,
    input  logic [DATA_W-1:0] din,
    input  logic              ren,
    input  logic              rt,
    output logic [DATA_W-1:0] dout,
    output logic              wflag,
    output logic              rflag,
    output logic              over_half
);
    localparam int PW = ADDR_W + 1;

    logic              rst_any;
    logic [PW-1:0]     wgray;
    logic [PW-1:0]     rgray;
    logic [PW-1:0]     wbin_at_r;
    logic [PW-1:0]     rbin_at_w;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic              we;
    logic [DATA_W-1:0] mem_q;

    assign rst_any = mrst | prst;

    dmfifo_ptr_cdc #(.PW(PW)) u_w2r (
        .clk     (rclk),
        .clr     (rst_any),
        .gray_in (wgray),
        .bin_out (wbin_at_r)
    );

    dmfifo_ptr_cdc #(.PW(PW)) u_r2w (
        .clk     (wclk),
        .clr     (rst_any),
        .gray_in (rgray),
        .bin_out (rbin_at_w)
    );

    dmfifo_mem #(.W(DATA_W), .AW(ADDR_W)) u_mem (
        .wclk  (wclk),
        .we    (we),
        .waddr (waddr),
        .wdata (din),
        .raddr (raddr),
        .rdata (mem_q)
    );

    dmfifo_wside #(.AW(ADDR_W)) u_wside (
        .clk       (wclk),
        .mrst      (mrst),
        .prst      (prst),
        .fwft_sel  (fwft_sel),
        .wen       (wen),
        .rbin_sync (rbin_at_w),
        .wgray     (wgray),
        .waddr     (waddr),
        .we        (we),
        .wflag     (wflag),
        .over_half (over_half)
    );

    dmfifo_rside #(.AW(ADDR_W), .W(DATA_W)) u_rside (
        .clk       (rclk),
        .mrst      (mrst),
        .prst      (prst),
        .fwft_sel  (fwft_sel),
        .ren       (ren),
        .rt        (rt),
        .wbin_sync (wbin_at_r),
        .mem_q     (mem_q),
        .rgray     (rgray),
        .raddr     (raddr),
        .dout      (dout),
        .rflag     (rflag)
    );

endmodule

// File: tb/dmfifo_tb.sv
`timescale 1ns/100ps
module dmfifo_tb;
    localparam int AW    = 3;
    localparam int DEPTH = 1 << AW;
    localparam int HALF  = DEPTH / 2;

    logic        wclk = 1'b0;
    logic        rclk = 1'b0;
    logic        mrst = 1'b1;
    logic        prst = 1'b0;
    logic        fwft_sel = 1'b0;
    logic        wen = 1'b0;
    logic [17:0] din = '0;
    logic        ren = 1'b0;
    logic        rt = 1'b0;
    logic [17:0] dout;
    logic        wflag;
    logic        rflag;
    logic        over_half;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [17:0] last;
    logic [17:0] got;

    always #2.5 wclk = ~wclk;   // 200 MHz write clock
    always #3.5 rclk = ~rclk;   // unrelated read clock

    dmfifo #(.DATA_W(18), .ADDR_W(AW)) u_dut (
        .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .fwft_sel(fwft_sel),
        .wen(wen), .din(din), .ren(ren), .rt(rt),
        .dout(dout), .wflag(wflag), .rflag(rflag), .over_half(over_half)
    );

    function automatic logic [17:0] val(input int n, input int i);
        return 18'((n * 1031 + i * 97 + 77) % 262144);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge rclk);
        repeat (6) @(negedge wclk);
    endtask

    task automatic hard_reset(input logic fw);
        @(negedge wclk);
        fwft_sel = fw;
        mrst = 1'b1;
        repeat (8) @(negedge wclk);
        mrst = 1'b0;
        fwft_sel = ~fw;
        settle();
    endtask

    task automatic soft_reset();
        @(negedge wclk);
        prst = 1'b1;
        repeat (8) @(negedge wclk);
        prst = 1'b0;
        settle();
    endtask

    task automatic push(input logic [17:0] d);
        @(negedge wclk);
        wen = 1'b1;
        din = d;
        @(negedge wclk);
        wen = 1'b0;
    endtask

    task automatic pop_std(output logic [17:0] d);
        @(negedge rclk);
        ren = 1'b1;
        @(negedge rclk);
        ren = 1'b0;
        d = dout;
    endtask

    task automatic pop_fwft(output logic [17:0] d);
        @(negedge rclk);
        d = dout;
        ren = 1'b1;
        @(negedge rclk);
        ren = 1'b0;
    endtask

    task automatic pulse_rt();
        @(negedge rclk);
        rt = 1'b1;
        @(negedge rclk);
        rt = 1'b0;
    endtask

    initial begin
        // ---------------- standard mode ----------------
        hard_reset(1'b0);
        @(negedge rclk);
        check("R1 std rflag", 32'(rflag), 32'd1);
        check("R1 dout", 32'(dout), 32'd0);
        @(negedge wclk);
        check("R1 std wflag", 32'(wflag), 32'd0);
        check("R1 over_half", 32'(over_half), 32'd0);
        check("R2 std mode despite select change", 32'(wflag), 32'd0);
        last = '0;

        for (int n = 1; n <= DEPTH; n++) begin
            for (int i = 0; i < n; i++) push(val(n, i));
            settle();
            check("R4 full", 32'(wflag), 32'(n == DEPTH));
            check("R9 over_half std", 32'(over_half), 32'(n > HALF));
            @(negedge rclk);
            check("R4 not empty", 32'(rflag), 32'd0);
            check("R3 no read no change", 32'(dout), 32'(last));
            for (int i = 0; i < n; i++) begin
                pop_std(got);
                check("R3 order", 32'(got), 32'(val(n, i)));
                last = got;
            end
            settle();
            @(negedge rclk);
            check("R4 empty", 32'(rflag), 32'd1);
        end

        // R7 overflow dropped
        for (int i = 0; i < DEPTH; i++) push(val(20, i));
        settle();
        push(18'h3FFFF);
        settle();
        check("R7 still full", 32'(wflag), 32'd1);
        for (int i = 0; i < DEPTH; i++) begin
            pop_std(got);
            check("R7 contents", 32'(got), 32'(val(20, i)));
            last = got;
        end
        settle();
        @(negedge rclk);
        check("R7 no extra word", 32'(rflag), 32'd1);

        // R8 underflow ignored
        @(negedge rclk);
        ren = 1'b1;
        repeat (3) @(negedge rclk);
        ren = 1'b0;
        check("R8 dout held", 32'(dout), 32'(last));
        check("R8 still empty", 32'(rflag), 32'd1);
        push(val(21, 0));
        settle();
        pop_std(got);
        check("R8 pointer intact", 32'(got), 32'(val(21, 0)));

        // R10 / R11 rewind in standard mode
        soft_reset();
        @(negedge rclk);
        check("R1 prst dout", 32'(dout), 32'd0);
        check("R1 prst empty", 32'(rflag), 32'd1);
        for (int i = 0; i < 4; i++) push(val(22, i));
        settle();
        for (int i = 0; i < 2; i++) begin
            pop_std(got);
            check("R3 pre-rewind", 32'(got), 32'(val(22, i)));
        end
        pulse_rt();
        check("R11 std empty on rewind", 32'(rflag), 32'd1);
        settle();
        for (int i = 0; i < 4; i++) begin
            pop_std(got);
            check("R10 reread", 32'(got), 32'(val(22, i)));
        end
        settle();
        @(negedge rclk);
        check("R10 write side kept", 32'(rflag), 32'd1);

        // ---------------- fall-through mode ----------------
        hard_reset(1'b1);
        @(negedge rclk);
        check("R1 fwft rflag", 32'(rflag), 32'd0);
        check("R1 fwft dout", 32'(dout), 32'd0);
        @(negedge wclk);
        check("R1 fwft wflag", 32'(wflag), 32'd1);
        check("R1 fwft over_half", 32'(over_half), 32'd0);

        for (int n = 1; n <= DEPTH + 1; n++) begin
            for (int i = 0; i < n; i++) push(val(40 + n, i));
            settle();
            check("R6 input ready", 32'(wflag), 32'(n != DEPTH + 1));
            check("R9 over_half fwft", 32'(over_half), 32'((n - 1) > HALF));
            @(negedge rclk);
            check("R5 word present", 32'(rflag), 32'd1);
            check("R5 fall through", 32'(dout), 32'(val(40 + n, 0)));
            for (int i = 0; i < n; i++) begin
                pop_fwft(got);
                check("R5 order", 32'(got), 32'(val(40 + n, i)));
            end
            settle();
            @(negedge rclk);
            check("R5 drained", 32'(rflag), 32'd0);
        end

        // R2 partial reset keeps fall-through
        soft_reset();
        @(negedge rclk);
        check("R2 prst keeps mode rflag", 32'(rflag), 32'd0);
        check("R1 prst fwft dout", 32'(dout), 32'd0);
        push(val(30, 0));
        settle();
        @(negedge rclk);
        check("R2 prst keeps fall-through", 32'(dout), 32'(val(30, 0)));

        // R10 / R11 rewind in fall-through mode
        soft_reset();
        for (int i = 0; i < 3; i++) push(val(31, i));
        settle();
        pop_fwft(got);
        check("R5 first", 32'(got), 32'(val(31, 0)));
        settle();
        @(negedge rclk);
        check("R5 second shown", 32'(dout), 32'(val(31, 1)));
        pulse_rt();
        check("R11 fwft not ready on rewind", 32'(rflag), 32'd0);
        settle();
        @(negedge rclk);
        check("R10 fwft ready again", 32'(rflag), 32'd1);
        for (int i = 0; i < 3; i++) begin
            pop_fwft(got);
            check("R10 fwft reread", 32'(got), 32'(val(31, i)));
        end

        // back to standard via master reset
        hard_reset(1'b0);
        @(negedge rclk);
        check("R2 mrst to std rflag", 32'(rflag), 32'd1);
        @(negedge wclk);
        check("R2 mrst to std wflag", 32'(wflag), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge wclk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule